// File: doc/BRIEF.md
# Ring Privilege Check Unit

This unit rules on one memory-protection question per request: may code running at a given ring touch a target segment? The target is either a data segment or a far transfer into a code segment, which may be conforming or non-conforming. Rings run from 0, the most trusted, to 3, the least trusted. The caller supplies four things: the current ring, the selector in use (its two low bits carry the requestor's ring), the target's descriptor ring, and the kind of target.

A request is taken on a valid/ready handshake. The verdict is registered and appears one cycle later. It holds three things: permit or fault, an error code, and the ring that is in force afterwards. The verdict stays on the outputs until the consumer takes it. No new request is taken while a verdict is waiting. Descriptor fetch, gates and stack switching are left to the surrounding logic.

Top module: `ring_access_checker`

## Requirements
- R1: After reset, respValid and respAllow are 0, respErrCode is 0 and reqReady is 1.
- R2: For kind 0 (data), the access is permitted only when the larger of the current ring and the selector ring (selector bits [1:0]) is at most the descriptor ring. For example, current 3, selector ring 0 and descriptor 0 faults.
- R3: For kind 1 (conforming code), the transfer is permitted exactly when the current ring is numerically greater than or equal to the descriptor ring. The selector ring has no effect.
- R4: For kind 2 (non-conforming code), the transfer is permitted only when the selector ring is at most the current ring and the current ring equals the descriptor ring.
- R5: A selector whose bits above bit 1 are all zero (null) always faults, whatever the kind or the rings.
- R6: On a fault, respErrCode is the selector with bits [1:0] cleared. On a permit, respErrCode is 0.
- R7: respLevel equals the current ring of the request in every case: permit, fault, conforming or not.
- R8: While respValid is 1, reqReady is 0. A verdict that is not taken stays unchanged until the cycle after respReady is 1.
- R9: A request accepted at one clock edge has its verdict valid right after the next edge, one cycle of latency.
- R10: Kind 3 is reserved and always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can take a request |
| reqCpl | input | 2 | Current ring |
| reqSel | input | SEL_W | Target selector, bits [1:0] give the requestor ring |
| reqDpl | input | 2 | Descriptor ring of the target |
| reqKind | input | 2 | 0 data, 1 conforming code, 2 non-conforming code, 3 reserved |
| respValid | output | 1 | Verdict present |
| respReady | input | 1 | Consumer takes the verdict |
| respAllow | output | 1 | 1 when access or transfer is permitted |
| respErrCode | output | SEL_W | Masked selector on a fault, else 0 |
| respLevel | output | 2 | Ring in force after the check |

## Verification
Random requests cover all ring combinations and all four kinds with a fixed seed. They separate the data rule, which uses the larger of the two rings, from the conforming rule, which ignores the selector ring and reverses the comparison, and from the non-conforming rule, which needs an exact match. Directed cases cover several patterns: a trusted selector ring paired with an untrusted current ring, a null selector with otherwise passing rings, a conforming target below the caller, and a non-conforming target one ring away. Random consumer stalls show whether the verdict holds steady and whether ready stays low while it waits.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int LEVEL_W = 2;

  typedef logic [LEVEL_W-1:0] privLevel_t;

  typedef enum logic [1:0] {
    KIND_DATA    = 2'd0,
    KIND_CONF    = 2'd1,
    KIND_NONCONF = 2'd2,
    KIND_RSVD    = 2'd3
  } segKind_e;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        respReady,
  output logic        respValid,
  output ctrlStrobe_t strobe
);
  logic pending;

  assign reqReady    = !pending;
  assign respValid   = pending;
  assign strobe.load = reqValid && !pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.load) begin
      pending <= 1'b1;
    end else if (respReady) begin
      pending <= 1'b0;
    end
  end

  // R9
  accept_to_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> respValid);

  // R8
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> respValid);
endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import ring_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  privLevel_t        reqCpl,
  input  logic [SEL_W-1:0]  reqSel,
  input  privLevel_t        reqDpl,
  input  logic [1:0]        reqKind,
  output logic              allowQ,
  output logic [SEL_W-1:0]  errQ,
  output privLevel_t        levelQ
);
  localparam int IDX_W = SEL_W - LEVEL_W;

  privLevel_t       selRpl;
  privLevel_t       effLevel;
  logic             selNull;
  logic             ruleOk;
  logic             allowD;
  logic [SEL_W-1:0] maskedSel;

  assign selRpl    = reqSel[LEVEL_W-1:0];
  assign selNull   = (reqSel[SEL_W-1:LEVEL_W] == '0);
  assign effLevel  = (reqCpl > selRpl) ? reqCpl : selRpl;
  assign maskedSel = {reqSel[SEL_W-1:LEVEL_W], {LEVEL_W{1'b0}}};

  always_comb begin
    unique case (segKind_e'(reqKind))
      KIND_DATA:    ruleOk = (effLevel <= reqDpl);
      KIND_CONF:    ruleOk = (reqCpl >= reqDpl);
      KIND_NONCONF: ruleOk = (selRpl <= reqCpl) && (reqCpl == reqDpl);
      default:      ruleOk = 1'b0;
    endcase
  end

  assign allowD = ruleOk && !selNull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allowQ <= 1'b0;
      errQ   <= '0;
      levelQ <= '0;
    end else if (strobe.load) begin
      allowQ <= allowD;
      errQ   <= allowD ? '0 : maskedSel;
      levelQ <= reqCpl;
    end
  end

  // R5
  null_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqSel[SEL_W-1:LEVEL_W] == {IDX_W{1'b0}}) |=> !allowQ);

  // R2
  data_eff_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqKind == 2'd0 && (reqCpl > reqDpl || selRpl > reqDpl)) |=> !allowQ);

  // R7
  level_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> levelQ == $past(reqCpl));

  // R6
  err_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !allowQ |-> errQ[LEVEL_W-1:0] == '0);
endmodule

// File: rtl/ring_access_checker.sv
module ring_access_checker
  import ring_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqCpl,
  input  logic [SEL_W-1:0] reqSel,
  input  logic [1:0]       reqDpl,
  input  logic [1:0]       reqKind,
  output logic             respValid,
  input  logic             respReady,
  output logic             respAllow,
  output logic [SEL_W-1:0] respErrCode,
  output logic [1:0]       respLevel
);
  ctrlStrobe_t strobe;

  ring_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .respReady(respReady), .respValid(respValid), .strobe(strobe)
  );

  ring_datapath #(.SEL_W(SEL_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCpl(reqCpl),
    .reqSel(reqSel), .reqDpl(reqDpl), .reqKind(reqKind),
    .allowQ(respAllow), .errQ(respErrCode), .levelQ(respLevel)
  );

  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> ($stable(respAllow) && $stable(respErrCode) && $stable(respLevel)));

  // R8
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);
endmodule

// File: tb/sim_ring_access_checker.sv
module sim_ring_access_checker;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqCpl = '0;
  logic [SW-1:0] reqSel = '0;
  logic [1:0] reqDpl = '0;
  logic [1:0] reqKind = '0;
  logic respValid;
  logic respReady = 1'b0;
  logic respAllow;
  logic [SW-1:0] respErrCode;
  logic [1:0] respLevel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_access_checker #(.SEL_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCpl(reqCpl), .reqSel(reqSel), .reqDpl(reqDpl), .reqKind(reqKind),
    .respValid(respValid), .respReady(respReady), .respAllow(respAllow),
    .respErrCode(respErrCode), .respLevel(respLevel)
  );

  function automatic bit expAllow(logic [1:0] c, logic [SW-1:0] s, logic [1:0] d, logic [1:0] k);
    logic [1:0] r;
    logic [1:0] e;
    r = s[1:0];
    e = (c > r) ? c : r;
    if (s[SW-1:2] == '0) return 1'b0;          // R5
    case (k)
      2'd0: return e <= d;                     // R2
      2'd1: return c >= d;                     // R3
      2'd2: return (r <= c) && (c == d);       // R4
      default: return 1'b0;                    // R10
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runReq(logic [1:0] c, logic [SW-1:0] s, logic [1:0] d, logic [1:0] k, int stall);
    bit a;
    a = expAllow(c, s, d, k);
    @(negedge clk);
    check("R8 ready idle", reqReady, 1);
    reqCpl = c; reqSel = s; reqDpl = d; reqKind = k; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqSel = ~s; reqCpl = ~c;
    check("R9 valid after one cycle", respValid, 1);
    check("R2 R3 R4 R5 R10 allow", respAllow, a);
    check("R6 errcode", respErrCode, a ? 0 : {s[SW-1:2], 2'b00});
    check("R7 level", respLevel, c);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R8 held valid", respValid, 1);
      check("R8 held allow", respAllow, a);
      check("R8 ready low", reqReady, 0);
    end
    respReady = 1'b1;
    @(negedge clk);
    respReady = 1'b0;
    check("R8 consumed", respValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 respValid", respValid, 0);
    check("R1 respAllow", respAllow, 0);
    check("R1 errcode", respErrCode, 0);
    check("R1 reqReady", reqReady, 1);
    rstN = 1'b1;
    // R2 trusted selector ring cannot lift untrusted current ring
    runReq(2'd3, 16'h0040, 2'd0, 2'd0, 0);
    runReq(2'd0, 16'h0043, 2'd2, 2'd0, 1);
    runReq(2'd1, 16'h0041, 2'd1, 2'd0, 0);
    // R3 conforming below caller, selector ring ignored
    runReq(2'd3, 16'h0010, 2'd0, 2'd1, 2);
    runReq(2'd0, 16'h0010, 2'd3, 2'd1, 0);
    // R4 non-conforming exact and off by one
    runReq(2'd2, 16'h0022, 2'd2, 2'd2, 0);
    runReq(2'd2, 16'h0022, 2'd1, 2'd2, 0);
    runReq(2'd1, 16'h0023, 2'd1, 2'd2, 0);
    // R5 null selector with passing rings
    runReq(2'd0, 16'h0000, 2'd3, 2'd0, 0);
    runReq(2'd3, 16'h0003, 2'd0, 2'd1, 0);
    // R10 reserved kind
    runReq(2'd0, 16'h0100, 2'd0, 2'd3, 0);
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [SW-1:0] s;
      s = SW'($urandom);
      if ($urandom_range(0, 7) == 0) s[SW-1:2] = '0;
      runReq(2'($urandom), s, 2'($urandom), 2'($urandom), int'($urandom_range(0, 3)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule